// File: doc/BRIEF.md
# Interval-Based Configuration Exploration Controller

This controller chooses one of several hardware configurations, such as a cache capacity setting or the number of active execution clusters, so that the setting fits the program running now. It splits execution into intervals. An interval is a run of committed instructions whose length is set by an input. Over each interval it counts committed instructions, elapsed cycles, branch events and miss events. At the end of each interval it compares the totals with a stored reference interval.

When branch frequency, miss frequency or instructions per cycle have moved by more than a relative margin, the controller treats this as a program phase change. It then tries every configuration for one interval each, in ascending order. It then settles on the one that delivered the highest IPC. The interval after a selection becomes the new reference.

IPC values are compared by cross-multiplying counts, so no divider is needed. The relative margin tightens on its own each time an exploration brings back the configuration that was already in use. This cuts down on explorations that gain nothing. The reconfigured resources live outside this block; it only drives the configuration index.

Top module: `phase_explore_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cfg_sel` is 0 and both `exploring` and `phase_chg` are 0.
- R2: An interval ends in the cycle where the running commit total, including that cycle's `commit_cnt`, reaches or exceeds `interval_len`. The cycle, branch and miss totals of that interval include that cycle. All totals restart from zero in the next cycle.
- R3: The first interval after reset, and the first interval after each selection, is stored as the reference. No phase check is made at its end.
- R4: At the end of a held interval, a phase change is detected if any one of three conditions holds. For branch count or miss count, the condition is |cur − ref| > (ref >> thr). For IPC, the condition is |cur_instr·ref_cyc − ref_instr·cur_cyc| > ((ref_instr·cur_cyc) >> thr). `phase_chg` is high for exactly the one cycle after that interval ends.
- R5: A detected phase change sets `exploring` and drives `cfg_sel` to 0 in the same cycle as the `phase_chg` pulse. After each later interval end, `cfg_sel` steps up by one, so each configuration runs for exactly one interval.
- R6: When the interval of the last configuration (index NUM_CFG−1) ends, `exploring` drops. `cfg_sel` takes the index with the highest instr/cycles, compared by cross-multiplication, and ties go to the lower index. `cfg_sel` then changes only at a later exploration.
- R7: The shift `thr` starts at 3. It is reduced by one, never below 1, each time an exploration selects the same index that was in use before that exploration began.
- R8: No phase check is made while exploring: `phase_chg` stays low in every cycle where `exploring` was already high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| commit_cnt | input | CMT_W | Instructions committed this cycle |
| branch_evt | input | 1 | One branch event this cycle |
| miss_evt | input | 1 | One miss event this cycle |
| interval_len | input | CNT_W | Committed instructions per interval |
| cfg_sel | output | IDX_W | Configuration index in force |
| exploring | output | 1 | Exploration sweep in progress |
| phase_chg | output | 1 | One-cycle pulse when a phase change is detected |

## Verification
The hardest situation to reach from the ports is the threshold tightening. It needs a full sweep that ends on the configuration already in use. After that, a later, smaller shift must no longer trigger a sweep. The bench reaches this by making its commit rate depend on the `cfg_sel` it observes. It alternates phases where one configuration wins outright, phases where every configuration ties (so index 0 wins and matches the previous choice), and phases with shifts in miss density or interval length. A behavioural model tracks the margin and predicts every output on every cycle.

// File: rtl/phase_explore_pkg.sv
package phase_explore_pkg;

  typedef enum logic [1:0] {
    M_REFRESH = 2'd0,
    M_HOLD    = 2'd1,
    M_EXPLORE = 2'd2
  } ctl_mode_e;

  // relative deviation of a plain count from its reference
  function automatic logic count_moved(input logic [63:0] cur,
                                       input logic [63:0] base,
                                       input logic [7:0]  sh);
    logic [63:0] diff;
    diff = (cur > base) ? (cur - base) : (base - cur);
    return diff > (base >> sh);
  endfunction

  // relative deviation of IPC, both sides scaled by cur_cyc*ref_cyc
  function automatic logic ipc_moved(input logic [63:0] ci, input logic [63:0] cc,
                                     input logic [63:0] ri, input logic [63:0] rc,
                                     input logic [7:0]  sh);
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] diff;
    a    = ci * rc;
    b    = ri * cc;
    diff = (a > b) ? (a - b) : (b - a);
    return diff > (b >> sh);
  endfunction

  // strict IPC comparison: ci/cc > bi/bc
  function automatic logic ipc_better(input logic [63:0] ci, input logic [63:0] cc,
                                      input logic [63:0] bi, input logic [63:0] bc);
    return (ci * bc) > (bi * cc);
  endfunction

endpackage

// File: rtl/interval_stats.sv
module interval_stats #(
  parameter int CNT_W = 20,
  parameter int CMT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMT_W-1:0] commit_cnt,
  input  logic             branch_evt,
  input  logic             miss_evt,
  input  logic [CNT_W-1:0] interval_len,
  output logic             ival_end,
  output logic [CNT_W-1:0] st_instr,
  output logic [CNT_W-1:0] st_cyc,
  output logic [CNT_W-1:0] st_br,
  output logic [CNT_W-1:0] st_ms
);
  logic [CNT_W-1:0] instr_q, cyc_q, br_q, ms_q;

  always_comb begin
    st_instr = instr_q + CNT_W'(commit_cnt);
    st_cyc   = cyc_q + CNT_W'(1);
    st_br    = br_q + CNT_W'(branch_evt);
    st_ms    = ms_q + CNT_W'(miss_evt);
    ival_end = (st_instr >= interval_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      cyc_q   <= '0;
      br_q    <= '0;
      ms_q    <= '0;
    end else if (ival_end) begin
      instr_q <= '0;
      cyc_q   <= '0;
      br_q    <= '0;
      ms_q    <= '0;
    end else begin
      instr_q <= st_instr;
      cyc_q   <= st_cyc;
      br_q    <= st_br;
      ms_q    <= st_ms;
    end
  end
endmodule

// File: rtl/phase_detector.sv
module phase_detector
  import phase_explore_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_load,
  input  logic [CNT_W-1:0] st_instr,
  input  logic [CNT_W-1:0] st_cyc,
  input  logic [CNT_W-1:0] st_br,
  input  logic [CNT_W-1:0] st_ms,
  input  logic [THR_W-1:0] thr,
  output logic             moved
);
  logic [CNT_W-1:0] ref_instr, ref_cyc, ref_br, ref_ms;
  logic             br_mv, ms_mv, ipc_mv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_instr <= '0;
      ref_cyc   <= '0;
      ref_br    <= '0;
      ref_ms    <= '0;
    end else if (ref_load) begin
      ref_instr <= st_instr;
      ref_cyc   <= st_cyc;
      ref_br    <= st_br;
      ref_ms    <= st_ms;
    end
  end

  always_comb begin
    br_mv  = count_moved(64'(st_br), 64'(ref_br), 8'(thr));
    ms_mv  = count_moved(64'(st_ms), 64'(ref_ms), 8'(thr));
    ipc_mv = ipc_moved(64'(st_instr), 64'(st_cyc), 64'(ref_instr), 64'(ref_cyc), 8'(thr));
    moved  = br_mv | ms_mv | ipc_mv;
  end
endmodule

// File: rtl/explore_fsm.sv
module explore_fsm
  import phase_explore_pkg::*;
#(
  parameter int NUM_CFG  = 4,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 20,
  parameter int THR_W    = 3,
  parameter int THR_INIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ival_end,
  input  logic             moved,
  input  logic [CNT_W-1:0] st_instr,
  input  logic [CNT_W-1:0] st_cyc,
  output logic [IDX_W-1:0] cfg_sel,
  output logic             exploring,
  output logic             phase_chg,
  output logic             ref_load,
  output logic [THR_W-1:0] thr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CFG - 1);

  ctl_mode_e        mode_q;
  logic [IDX_W-1:0] cfg_q, best_idx, prev_cfg, winner;
  logic [CNT_W-1:0] best_i, best_c;
  logic [THR_W-1:0] thr_q;
  logic             phase_q, take, last;

  always_comb begin
    take      = (cfg_q == '0) ||
                ipc_better(64'(st_instr), 64'(st_cyc), 64'(best_i), 64'(best_c));
    last      = (cfg_q == LAST_IDX);
    winner    = take ? cfg_q : best_idx;
    ref_load  = ival_end && (mode_q == M_REFRESH);
    cfg_sel   = cfg_q;
    exploring = (mode_q == M_EXPLORE);
    phase_chg = phase_q;
    thr       = thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_REFRESH;
      cfg_q    <= '0;
      best_idx <= '0;
      prev_cfg <= '0;
      best_i   <= '0;
      best_c   <= '0;
      thr_q    <= THR_W'(THR_INIT);
      phase_q  <= 1'b0;
    end else begin
      phase_q <= 1'b0;
      if (ival_end) begin
        unique case (mode_q)
          M_REFRESH: mode_q <= M_HOLD;
          M_HOLD: if (moved) begin
            phase_q  <= 1'b1;
            mode_q   <= M_EXPLORE;
            prev_cfg <= cfg_q;
            cfg_q    <= '0;
          end
          M_EXPLORE: begin
            if (take) begin
              best_idx <= cfg_q;
              best_i   <= st_instr;
              best_c   <= st_cyc;
            end
            if (last) begin
              cfg_q  <= winner;
              mode_q <= M_REFRESH;
              if (winner == prev_cfg && thr_q > THR_W'(1))
                thr_q <= thr_q - THR_W'(1);
            end else begin
              cfg_q <= cfg_q + IDX_W'(1);
            end
          end
          default: mode_q <= M_REFRESH;
        endcase
      end
    end
  end
endmodule

// File: rtl/phase_explore_ctrl.sv
module phase_explore_ctrl #(
  parameter int NUM_CFG  = 4,
  parameter int CNT_W    = 20,
  parameter int CMT_W    = 3,
  parameter int THR_W    = 3,
  parameter int THR_INIT = 3,
  localparam int IDX_W   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMT_W-1:0] commit_cnt,
  input  logic             branch_evt,
  input  logic             miss_evt,
  input  logic [CNT_W-1:0] interval_len,
  output logic [IDX_W-1:0] cfg_sel,
  output logic             exploring,
  output logic             phase_chg
);
  // internal events brought out for the checker
  logic             ival_end;
  logic             moved;
  logic             ref_load;
  logic [THR_W-1:0] thr_val;
  logic [CNT_W-1:0] st_instr, st_cyc, st_br, st_ms;

  interval_stats #(.CNT_W(CNT_W), .CMT_W(CMT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .commit_cnt(commit_cnt), .branch_evt(branch_evt),
    .miss_evt(miss_evt), .interval_len(interval_len), .ival_end(ival_end),
    .st_instr(st_instr), .st_cyc(st_cyc), .st_br(st_br), .st_ms(st_ms)
  );

  phase_detector #(.CNT_W(CNT_W), .THR_W(THR_W)) u_det (
    .clk(clk), .rst_n(rst_n), .ref_load(ref_load), .st_instr(st_instr),
    .st_cyc(st_cyc), .st_br(st_br), .st_ms(st_ms), .thr(thr_val), .moved(moved)
  );

  explore_fsm #(.NUM_CFG(NUM_CFG), .IDX_W(IDX_W), .CNT_W(CNT_W),
                .THR_W(THR_W), .THR_INIT(THR_INIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ival_end(ival_end), .moved(moved),
    .st_instr(st_instr), .st_cyc(st_cyc), .cfg_sel(cfg_sel),
    .exploring(exploring), .phase_chg(phase_chg), .ref_load(ref_load), .thr(thr_val)
  );
endmodule

// File: rtl/phase_explore_chk.sv
module phase_explore_chk #(
  parameter int IDX_W = 2,
  parameter int THR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] cfg_sel,
  input logic             exploring,
  input logic             phase_chg,
  input logic             ival_end,
  input logic [THR_W-1:0] thr_val
);
  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |=> !phase_chg);

  // R4
  pulse_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |-> $past(ival_end));

  // R5
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |-> (exploring && cfg_sel == '0));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ival_end) |-> $stable(cfg_sel));

  // R8
  no_check_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exploring) && exploring) |-> !phase_chg);

  // R7
  thr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_val != '0);

  // R7
  thr_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_val <= $past(thr_val));
endmodule

bind phase_explore_ctrl phase_explore_chk #(.IDX_W(IDX_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .exploring(exploring),
  .phase_chg(phase_chg), .ival_end(ival_end), .thr_val(thr_val)
);

// File: tb/phase_explore_ctrl_tb.sv
`timescale 1ns/1ps
module phase_explore_ctrl_tb;
  localparam int NCFG = 4;
  localparam int CW   = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    commit_cnt = '0;
  logic          branch_evt = 1'b0;
  logic          miss_evt = 1'b0;
  logic [CW-1:0] interval_len = CW'(20);
  logic [1:0]    cfg_sel;
  logic          exploring, phase_chg;

  always #2 clk = ~clk;

  phase_explore_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .commit_cnt(commit_cnt), .branch_evt(branch_evt),
    .miss_evt(miss_evt), .interval_len(interval_len), .cfg_sel(cfg_sel),
    .exploring(exploring), .phase_chg(phase_chg)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference
  longint m_i, m_c, m_b, m_m, r_i, r_c, r_b, r_m, b_i, b_c;
  int     mmode, thr, b_idx, prev, e_cfg, model_pulses;
  bit     e_expl, e_phase;

  function automatic bit dev(longint x, longint r, int s);
    longint d;
    d = (x > r) ? x - r : r - x;
    return d > r / (longint'(1) << s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_i = 0; m_c = 0; m_b = 0; m_m = 0;
      mmode = 0; thr = 3; b_idx = 0; prev = 0; e_cfg = 0;
      e_expl = 0; e_phase = 0; b_i = 0; b_c = 0;
    end else begin
      longint s_i, s_c, s_b, s_m, a, b;
      bit mv, take;
      s_i = m_i + commit_cnt; s_c = m_c + 1;
      s_b = m_b + branch_evt; s_m = m_m + miss_evt;
      e_phase = 0;
      if (s_i >= longint'(interval_len)) begin
        m_i = 0; m_c = 0; m_b = 0; m_m = 0;
        if (mmode == 0) begin
          r_i = s_i; r_c = s_c; r_b = s_b; r_m = s_m; mmode = 1;
        end else if (mmode == 1) begin
          a = s_i * r_c; b = r_i * s_c;
          mv = dev(s_b, r_b, thr) || dev(s_m, r_m, thr) || dev(a, b, thr);
          if (mv) begin
            e_phase = 1; mmode = 2; prev = e_cfg; e_cfg = 0; model_pulses++;
          end
        end else begin
          take = (e_cfg == 0) || (s_i * b_c > b_i * s_c);
          if (take) begin b_idx = e_cfg; b_i = s_i; b_c = s_c; end
          if (e_cfg == NCFG - 1) begin
            e_cfg = b_idx; mmode = 0;
            if (b_idx == prev && thr > 1) thr--;
          end else e_cfg++;
        end
      end else begin
        m_i = s_i; m_c = s_c; m_b = s_b; m_m = s_m;
      end
      e_expl = (mmode == 2);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // stimulus: commit rate depends on phase and on the observed configuration
  int ph = 0;
  int tick = 0;
  int seen_pulses = 0;
  bit seen_hold2 = 0;
  int bper[6] = '{4, 2, 3, 3, 5, 5};
  int mper[6] = '{16, 16, 8, 4, 16, 1};

  function automatic int rate(int p, int c, int t);
    case (p)
      0: return 2;
      1: return (c == 2) ? 3 : 1;
      2: return (c == 1) ? 4 : ((t % 3 == 0) ? 2 : 1);
      3: return 2;
      4: return (c == 0) ? 5 : 2;
      default: return 2;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 cfg_sel", int'(cfg_sel), 0);
    chk("R1 exploring", int'(exploring), 0);
    chk("R1 phase_chg", int'(phase_chg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset
    chk("R1 cfg_sel post", int'(cfg_sel), 0);
    chk("R1 exploring post", int'(exploring), 0);
    for (int p = 0; p < 6; p++) begin
      ph = p;
      if (p == 4) interval_len = CW'(37);
      for (int k = 0; k < 500; k++) begin
        // compare outputs against the model (R2 timing is implied in every check)
        chk("R5 R6 cfg_sel", int'(cfg_sel), e_cfg);
        chk("R5 R8 exploring", int'(exploring), int'(e_expl));
        chk("R2 R3 R4 R7 phase_chg", int'(phase_chg), int'(e_phase));
        if (phase_chg) seen_pulses++;
        if (!exploring && cfg_sel == 2'd2) seen_hold2 = 1;
        tick++;
        commit_cnt = 3'(rate(ph, int'(cfg_sel), tick));
        branch_evt = (tick % bper[ph]) == 0;
        miss_evt   = (tick % mper[ph]) == 0;
        @(negedge clk);
      end
    end
    // R4 explorations were triggered and counted identically
    chk("R4 pulse count", seen_pulses, model_pulses);
    checks++;
    if (seen_pulses == 0) begin
      fails++;
      $display("FAIL R4 no phase change actual=0 expected>0");
    end
    // R6 the phase favouring index 2 ended holding index 2
    chk("R6 held index 2 seen", int'(seen_hold2), 1);
    // R7 the tie phase selected 0 again and tightened the margin
    chk("R7 model thr below initial", int'(thr < 3), 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule